// File: doc/BRIEF.md
# Sixteen-Bit Register-Machine Execution Core

This block is a multicycle execution core for a compact 16-bit instruction set. It holds a bank of sixteen 16-bit general registers, one unified memory of 4096 16-bit words for code and data, a program counter and a single status flag. After reset the core sweeps the whole memory to zero and then raises a ready output.

While the core is ready, a test environment streams program words through a load port. The words go to ascending addresses starting at 0. The environment may also preset the status flag. A start pulse closes the load, places the halt word 0xDEAD directly after the last word and begins execution.

Each instruction is fetched, decoded and executed in turn until the word at the PC is 0xDEAD. At that point the core stops with the PC still on that word and raises a halted output. Debug ports expose any register, the PC and any memory word, so a bench can compare the final machine state against a reference.

Top module: `reg16_core`

## Requirements
- R1: Reset clears the registers, the PC, the status flag and the overflow indication. The memory is then swept to zero, and `ld_ready_o` rises once the sweep is done. Memory written before the reset reads back as zero afterwards.
- R2: While ready, each cycle with `ld_en_i` high stores `ld_data_i` at the next ascending address, starting from 0. A cycle with `start_i` high and `ld_en_i` low writes 0xDEAD at the next free address, if one remains, and begins execution.
- R3: A load word offered after all 4096 words are filled is discarded and sets `ld_ovf_o`. A start with a full memory also sets it. Once set, `ld_ovf_o` stays high until reset.
- R4: Bits 15:12 hold the opcode. The PC advances by one past the fetched word before the instruction executes. The PC is 12 bits wide and wraps.
- R5: Opcodes 0 (add), 1 (subtract), 4 (bitwise and) and 5 (bitwise or) write f(reg[7:4], reg[3:0]) into the register named by bits 11:8, modulo 2^16.
- R6: Opcode 2 keeps the low 16 bits of the product. Opcode 3 writes the unsigned quotient, or 0xFFFF when the divisor register is zero.
- R7: Opcode 6 writes the inverse of reg[7:4] into reg[11:8]. Opcode 0xA writes bits 7:0, zero-extended, into reg[11:8].
- R8: Opcode 0xB loads mem[reg[7:4]] into reg[11:8]. Opcode 0xC stores reg[11:8] to mem[reg[7:4]]. Only the low 12 bits of the address register are used.
- R9: Opcode 0xE adds bits 11:0, sign-extended from bit 11, to the already-advanced PC.
- R10: Opcode 0xF performs the same relative jump only when the status flag is 1, and otherwise falls through. The flag is set only through `flag_set_i`/`flag_val_i` while ready, and no instruction changes it.
- R11: On fetching 0xDEAD the core does not execute it. It raises `halted_o` and holds the PC on that word until reset.
- R12: Opcodes 7, 8, 9 and 0xD change no register or memory and only advance the PC. Each one raises `bad_op_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_ready_o | output | 1 | Load phase active, load port accepted |
| ld_en_i | input | 1 | Store `ld_data_i` at next load address |
| ld_data_i | input | 16 | Program or data word to load |
| start_i | input | 1 | End load, append halt word, run |
| flag_set_i | input | 1 | Write status flag during load phase |
| flag_val_i | input | 1 | Value for the status flag |
| ld_ovf_o | output | 1 | Sticky load overflow |
| halted_o | output | 1 | Halt word reached |
| bad_op_o | output | 1 | One-cycle pulse on an unused opcode |
| dbg_reg_sel_i | input | 4 | Register to observe |
| dbg_reg_o | output | 16 | Selected register value |
| dbg_pc_o | output | 16 | Program counter, zero-extended |
| dbg_mem_addr_i | input | 12 | Memory word to observe |
| dbg_mem_o | output | 16 | Selected memory word |

## Verification
`ld_ready_o` rises 4096 cycles after reset is released. A loaded word is readable on `dbg_mem_o` at the falling edge that follows the rising edge that took it. Most instructions take three cycles (fetch, decode, execute), a load from memory takes four, and `halted_o` rises one cycle after the decode that sees 0xDEAD. The bench does not predict the exact halt cycle. It polls `halted_o` at falling edges within a bounded wait, counts `bad_op_o` at falling edges because the pulse spans a whole execute cycle, and reads the combinational debug ports one time step after it changes their select inputs.

// File: rtl/reg16_pkg.sv
package reg16_pkg;
  localparam int RSEL_W = 4;
  localparam logic [15:0] HALT_WORD = 16'hDEAD;

  localparam logic [3:0] OP_ADD = 4'h0;
  localparam logic [3:0] OP_SUB = 4'h1;
  localparam logic [3:0] OP_MUL = 4'h2;
  localparam logic [3:0] OP_DIV = 4'h3;
  localparam logic [3:0] OP_AND = 4'h4;
  localparam logic [3:0] OP_ORR = 4'h5;
  localparam logic [3:0] OP_NOT = 4'h6;
  localparam logic [3:0] OP_MOV = 4'hA;
  localparam logic [3:0] OP_LDR = 4'hB;
  localparam logic [3:0] OP_STR = 4'hC;
  localparam logic [3:0] OP_JMP = 4'hE;
  localparam logic [3:0] OP_JEQ = 4'hF;

  typedef enum logic [2:0] {
    ST_CLR, ST_LOAD, ST_FETCH, ST_DEC, ST_EXEC, ST_LDWB, ST_HALT
  } state_e;
endpackage

// File: rtl/reg16_mem.sv
module reg16_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

  assign dbg_data_o = mem_q[dbg_addr_i];
endmodule

// File: rtl/reg16_regfile.sv
module reg16_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4,
  parameter int NRD    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SEL_W-1:0]             wsel_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [NRD-1:0][SEL_W-1:0]    rsel_i,
  output logic [NRD-1:0][DATA_W-1:0]   rdata_o
);
  localparam int NREG = 1 << SEL_W;

  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wsel_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = regs_q[rsel_i[g]];
  end

  // R5: a write is visible in the target register the next cycle
  a_r5_wr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wsel_i)] == $past(wdata_i));
endmodule

// File: rtl/reg16_alu.sv
module reg16_alu
  import reg16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o
);
  always_comb begin
    wr_o  = 1'b1;
    res_o = '0;
    case (op_i)
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_MUL: res_o = a_i * b_i;
      OP_DIV: res_o = (b_i == '0) ? '1 : a_i / b_i;
      OP_AND: res_o = a_i & b_i;
      OP_ORR: res_o = a_i | b_i;
      OP_NOT: res_o = ~a_i;
      OP_MOV: res_o = DATA_W'(imm_i);
      default: wr_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/reg16_core.sv
module reg16_core
  import reg16_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              ld_ready_o,
  input  logic              ld_en_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              start_i,
  input  logic              flag_set_i,
  input  logic              flag_val_i,
  output logic              ld_ovf_o,
  output logic              halted_o,
  output logic              bad_op_o,
  input  logic [RSEL_W-1:0] dbg_reg_sel_i,
  output logic [DATA_W-1:0] dbg_reg_o,
  output logic [DATA_W-1:0] dbg_pc_o,
  input  logic [ADDR_W-1:0] dbg_mem_addr_i,
  output logic [DATA_W-1:0] dbg_mem_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(DEPTH);
  localparam int NRD = 4;

  state_e state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic flag_q, ovf_q;
  logic [ADDR_W:0] ptr_q;

  logic [3:0] op;
  logic full;
  logic mem_we;
  logic [ADDR_W-1:0] mem_wa, mem_ra;
  logic [DATA_W-1:0] mem_wd, mem_rd;
  logic rf_we;
  logic [DATA_W-1:0] rf_wd;
  logic [NRD-1:0][RSEL_W-1:0] rf_sel;
  logic [NRD-1:0][DATA_W-1:0] rf_rd;
  logic [DATA_W-1:0] alu_res, joff;
  logic alu_wr;
  logic [ADDR_W-1:0] pc_jmp;

  assign op   = ir_q[15:12];
  assign full = (ptr_q == FULL);
  // port 0: field 11:8, 1: field 7:4, 2: field 3:0, 3: debug
  assign rf_sel = {dbg_reg_sel_i, ir_q[3:0], ir_q[7:4], ir_q[11:8]};
  assign joff   = {{(DATA_W-12){ir_q[11]}}, ir_q[11:0]};
  assign pc_jmp = pc_q + joff[ADDR_W-1:0];

  reg16_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk_i      (clk_i),
    .we_i       (mem_we),
    .waddr_i    (mem_wa),
    .wdata_i    (mem_wd),
    .raddr_i    (mem_ra),
    .rdata_o    (mem_rd),
    .dbg_addr_i (dbg_mem_addr_i),
    .dbg_data_o (dbg_mem_o)
  );

  reg16_regfile #(.DATA_W(DATA_W), .SEL_W(RSEL_W), .NRD(NRD)) rf_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .wsel_i  (ir_q[11:8]),
    .wdata_i (rf_wd),
    .rsel_i  (rf_sel),
    .rdata_o (rf_rd)
  );

  reg16_alu #(.DATA_W(DATA_W)) alu_i (
    .op_i  (op),
    .a_i   (rf_rd[1]),
    .b_i   (rf_rd[2]),
    .imm_i (ir_q[7:0]),
    .res_o (alu_res),
    .wr_o  (alu_wr)
  );

  always_comb begin
    mem_we = 1'b0;
    mem_wa = ptr_q[ADDR_W-1:0];
    mem_wd = '0;
    mem_ra = pc_q;
    case (state_q)
      ST_CLR: mem_we = 1'b1;
      ST_LOAD: begin
        if (ld_en_i && !full) begin
          mem_we = 1'b1;
          mem_wd = ld_data_i;
        end else if (!ld_en_i && start_i && !full) begin
          mem_we = 1'b1;
          mem_wd = HALT_WORD;
        end
      end
      ST_EXEC: begin
        if (op == OP_STR) begin
          mem_we = 1'b1;
          mem_wa = rf_rd[1][ADDR_W-1:0];
          mem_wd = rf_rd[0];
        end
        if (op == OP_LDR) mem_ra = rf_rd[1][ADDR_W-1:0];
      end
      default: ;
    endcase
  end

  assign rf_we = (state_q == ST_EXEC && alu_wr) || (state_q == ST_LDWB);
  assign rf_wd = (state_q == ST_LDWB) ? mem_rd : alu_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLR;
      pc_q    <= '0;
      ir_q    <= '0;
      flag_q  <= 1'b0;
      ovf_q   <= 1'b0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ST_CLR: begin
          if (ptr_q[ADDR_W-1:0] == '1) begin
            ptr_q   <= '0;
            state_q <= ST_LOAD;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_LOAD: begin
          if (flag_set_i) flag_q <= flag_val_i;
          if (ld_en_i) begin
            if (full) ovf_q <= 1'b1;
            else      ptr_q <= ptr_q + 1'b1;
          end else if (start_i) begin
            if (full) ovf_q <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_DEC;
        ST_DEC: begin
          if (mem_rd == HALT_WORD) begin
            state_q <= ST_HALT;
          end else begin
            ir_q    <= mem_rd;
            pc_q    <= pc_q + 1'b1;
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (op == OP_JMP || (op == OP_JEQ && flag_q)) pc_q <= pc_jmp;
          state_q <= (op == OP_LDR) ? ST_LDWB : ST_FETCH;
        end
        ST_LDWB: state_q <= ST_FETCH;
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_CLR;
      endcase
    end
  end

  assign ld_ready_o = (state_q == ST_LOAD);
  assign ld_ovf_o   = ovf_q;
  assign halted_o   = (state_q == ST_HALT);
  assign bad_op_o   = (state_q == ST_EXEC) &&
                      (op == 4'h7 || op == 4'h8 || op == 4'h9 || op == 4'hD);
  assign dbg_reg_o  = rf_rd[3];
  assign dbg_pc_o   = DATA_W'(pc_q);

  // R11: halt is final and the PC stays on the halt word
  a_r11_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(dbg_pc_o));

  // R4: a decoded non-halt word moves the PC on by exactly one
  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC && mem_rd != HALT_WORD) |=> pc_q == $past(pc_q) + 1'b1);

  // R12: the unused-opcode indication lasts one cycle
  a_r12_bad_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |=> !bad_op_o);

  // R3: overflow is sticky
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ovf_o |=> ld_ovf_o);

  // R2: the load port is open only until start
  a_r2_run_leaves_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ready_o && start_i && !ld_en_i) |=> !ld_ready_o);
endmodule

// File: tb/reg16_core_tb_top.sv
module reg16_core_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        ld_ready, ld_en, start, flag_set, flag_val, ld_ovf, halted, bad_op;
  logic [15:0] ld_data, dbg_reg, dbg_pc, dbg_mem;
  logic [3:0]  dbg_sel;
  logic [11:0] dbg_addr;

  reg16_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_ready_o(ld_ready), .ld_en_i(ld_en),
    .ld_data_i(ld_data), .start_i(start), .flag_set_i(flag_set),
    .flag_val_i(flag_val), .ld_ovf_o(ld_ovf), .halted_o(halted),
    .bad_op_o(bad_op), .dbg_reg_sel_i(dbg_sel), .dbg_reg_o(dbg_reg),
    .dbg_pc_o(dbg_pc), .dbg_mem_addr_i(dbg_addr), .dbg_mem_o(dbg_mem)
  );

  int n_chk = 0, n_err = 0, cyc = 0, bad_cnt = 0;
  logic [15:0] prog [4096];
  int prog_len;
  logic [15:0] m_mem [4096];
  logic [15:0] m_reg [16];
  logic [11:0] m_pc;
  bit m_flag;
  int m_bad;

  always @(negedge clk) if (rst_n && bad_op) bad_cnt++;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic peek_mem(input logic [11:0] a, output logic [15:0] v);
    dbg_addr = a; #1; v = dbg_mem;
  endtask

  task automatic peek_reg(input logic [3:0] r, output logic [15:0] v);
    dbg_sel = r; #1; v = dbg_reg;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ld_en = 0; start = 0; flag_set = 0; flag_val = 0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!ld_ready) @(negedge clk);
    bad_cnt = 0;
  endtask

  // reference machine built from the requirements
  task automatic m_step(input logic [15:0] ins);
    logic [3:0] op, d, s, t;
    logic [15:0] x, y;
    op = ins[15:12]; d = ins[11:8]; s = ins[7:4]; t = ins[3:0];
    x = m_reg[s]; y = m_reg[t];
    case (op)
      4'h0: m_reg[d] = x + y;
      4'h1: m_reg[d] = x - y;
      4'h2: m_reg[d] = x * y;
      4'h3: m_reg[d] = (y == 0) ? 16'hFFFF : x / y;
      4'h4: m_reg[d] = x & y;
      4'h5: m_reg[d] = x | y;
      4'h6: m_reg[d] = ~x;
      4'hA: m_reg[d] = {8'h00, ins[7:0]};
      4'hB: m_reg[d] = m_mem[x[11:0]];
      4'hC: m_mem[x[11:0]] = m_reg[d];
      4'hE: m_pc = m_pc + ins[11:0];
      4'hF: if (m_flag) m_pc = m_pc + ins[11:0];
      default: m_bad++;
    endcase
  endtask

  task automatic model_run(input bit flag, output bit ok);
    logic [15:0] ins;
    for (int i = 0; i < 4096; i++) m_mem[i] = (i < prog_len) ? prog[i] : 16'h0;
    if (prog_len < 4096) m_mem[prog_len] = 16'hDEAD;
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_pc = '0; m_flag = flag; m_bad = 0; ok = 1'b0;
    for (int st = 0; st < 3000; st++) begin
      if (m_mem[m_pc] == 16'hDEAD) begin ok = 1'b1; break; end
      ins = m_mem[m_pc];
      m_pc = m_pc + 1'b1;
      m_step(ins);
    end
  endtask

  task automatic load_prog(input bit flag);
    flag_set = 1; flag_val = flag; @(negedge clk); flag_set = 0;
    for (int i = 0; i < prog_len; i++) begin
      ld_en = 1; ld_data = prog[i]; @(negedge clk);
    end
    ld_en = 0; start = 1; @(negedge clk); start = 0;
  endtask

  task automatic run_prog(input string tag, input bit flag, output bit ok);
    int w;
    int mm;
    logic [15:0] v;
    model_run(flag, ok);
    if (!ok) return;
    do_reset();
    load_prog(flag);
    w = 0;
    while (!halted && w < 30000) begin @(negedge clk); w++; end
    check("R11", {tag, " halted"}, halted, 1);
    for (int r = 0; r < 16; r++) begin
      peek_reg(r[3:0], v);
      check(tag, $sformatf("reg %0d", r), v, m_reg[r]);
    end
    check("R4", {tag, " pc"}, dbg_pc, {4'h0, m_pc});
    check("R12", {tag, " bad count"}, bad_cnt, m_bad);
    mm = 0;
    for (int a = 0; a < 4096; a++) begin
      peek_mem(a[11:0], v);
      if (v !== m_mem[a] && mm == 0) begin
        mm = 1;
        check("R8", $sformatf("%s mem[%0h]", tag, a), v, m_mem[a]);
      end
    end
    if (mm == 0) check("R8", {tag, " memory image"}, 0, 0);
  endtask

  task automatic set_prog(input logic [15:0] w [], input int n);
    for (int i = 0; i < n; i++) prog[i] = w[i];
    prog_len = n;
  endtask

  initial begin
    bit ok;
    logic [15:0] v;
    logic [15:0] p [];
    void'($urandom(32'd2024));
    dbg_sel = 0; dbg_addr = 0;

    // R1: reset state
    do_reset();
    check("R1", "ready", ld_ready, 1);
    check("R1", "pc", dbg_pc, 0);
    check("R1", "halted", halted, 0);
    check("R1", "ovf", ld_ovf, 0);
    peek_reg(4'd9, v); check("R1", "reg9", v, 0);
    peek_mem(12'hABC, v); check("R1", "mem[abc]", v, 0);

    // R7, R2: one move per register
    p = new[16];
    for (int i = 0; i < 16; i++) p[i] = {4'hA, i[3:0], 4'h0, i[3:0]};
    set_prog(p, 16);
    run_prog("R7", 0, ok);
    peek_mem(12'd16, v); check("R2", "halt word appended", v, 16'hDEAD);
    peek_mem(12'd3, v); check("R2", "word 3", v, 16'hA303);
    check("R4", "pc after 16 moves", dbg_pc, 16);

    // R5, R6, R7: arithmetic corners
    p = '{16'hA1F0, 16'hA20F, 16'hA300, 16'h0412, 16'h1521, 16'hA6FF, 16'h2766,
          16'h2877, 16'h3912, 16'h3A13, 16'h4B16, 16'h5C12, 16'h6D10, 16'h1E31};
    set_prog(p, 14);
    run_prog("R6", 0, ok);
    peek_reg(4'd10, v); check("R6", "div by zero", v, 16'hFFFF);
    peek_reg(4'd8, v);  check("R6", "mul low half", v, 16'hFC01);
    peek_reg(4'd13, v); check("R7", "not", v, 16'hFF0F);
    peek_reg(4'd5, v);  check("R5", "sub wrap", v, 16'hFF1F);

    // R8: memory access, high address bits ignored
    p = '{16'hA140, 16'hA25A, 16'hC210, 16'hB310, 16'h6800, 16'hB980,
          16'hC280, 16'hBA80};
    set_prog(p, 8);
    run_prog("R8", 0, ok);
    peek_reg(4'd3, v);  check("R8", "load back", v, 16'h005A);
    peek_reg(4'd9, v);  check("R8", "load fff before store", v, 16'h0000);
    peek_reg(4'd10, v); check("R8", "load fff after store", v, 16'h005A);
    peek_mem(12'hFFF, v); check("R8", "mem[fff]", v, 16'h005A);

    // R1: memory cleared by a new reset
    do_reset();
    peek_mem(12'h040, v); check("R1", "mem[040] after reset", v, 16'h0000);

    // R9: forward then backward jump
    p = '{16'hE002, 16'hA511, 16'hDEAD, 16'hEFFD};
    set_prog(p, 4);
    run_prog("R9", 0, ok);
    check("R9", "pc at halt", dbg_pc, 16'd2);
    peek_reg(4'd5, v); check("R9", "reg5", v, 16'h0011);

    // R10: conditional jump with flag 1 and 0
    p = '{16'hA105, 16'hF001, 16'hA107};
    set_prog(p, 3);
    run_prog("R10", 1, ok);
    peek_reg(4'd1, v); check("R10", "taken", v, 16'h0005);
    run_prog("R10", 0, ok);
    peek_reg(4'd1, v); check("R10", "not taken", v, 16'h0007);

    // R12: unused opcodes
    p = '{16'h7123, 16'h8000, 16'hD456, 16'hA101};
    set_prog(p, 4);
    run_prog("R12", 0, ok);
    check("R12", "pulses", bad_cnt, 3);
    peek_reg(4'd1, v); check("R12", "reg1", v, 16'h0001);

    // R11: halt in mid-program holds
    p = '{16'hA101, 16'hDEAD, 16'hA102};
    set_prog(p, 3);
    run_prog("R11", 0, ok);
    repeat (20) @(negedge clk);
    check("R11", "pc held", dbg_pc, 16'd1);
    peek_reg(4'd1, v); check("R11", "no exec past halt", v, 16'h0001);

    // R5: random programs
    for (int k = 0; k < 12; k++) begin
      do begin
        int n;
        n = 10 + $urandom % 30;
        for (int i = 0; i < n; i++) begin
          int sel;
          logic [3:0] op;
          logic [11:0] f;
          sel = $urandom % 16;
          f = 12'($urandom);
          if (i < 6) op = 4'hA;
          else if (sel < 7) op = sel[3:0];
          else case (sel)
            7: op = 4'hA; 8: op = 4'hB; 9: op = 4'hC;
            10: op = 4'h7; 11: op = 4'h8; 12: op = 4'h9; 13: op = 4'hD;
            14: op = 4'h2; default: op = 4'h3;
          endcase
          prog[i] = {op, f};
        end
        prog_len = n;
        model_run(0, ok);
      end while (!ok);
      run_prog("R5", 0, ok);
    end

    // R3: overflow on load
    do_reset();
    for (int i = 0; i < 4096; i++) begin
      ld_en = 1; ld_data = 16'(i) ^ 16'h5A5A; @(negedge clk);
    end
    check("R3", "not yet full", ld_ovf, 0);
    ld_data = 16'hBEEF; @(negedge clk); ld_en = 0;
    check("R3", "overflow set", ld_ovf, 1);
    repeat (3) @(negedge clk);
    check("R3", "overflow sticky", ld_ovf, 1);
    peek_mem(12'h000, v); check("R3", "word 0 kept", v, 16'h5A5A);
    peek_mem(12'hFFF, v); check("R3", "last word", v, 16'h0FFF ^ 16'h5A5A);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule